// File: doc/BRIEF.md
# Watchdog Timer with Guarded Shutdown

This block supervises a system by counting ticks of a slow watchdog oscillator and pulsing a system reset when a software-selected number of ticks has passed without a restart. Software keeps the system alive by strobing the restart input often enough. The oscillator reaches the block as a one-cycle tick enable that is synchronous to the system clock, so the whole block runs in a single clock domain.

A five-bit control register holds a three-bit timeout select, an enable bit and an arming bit. The watchdog is easy to start and hard to stop. A single write can turn it on. Turning it off takes two writes. The first sets the arming bit and the enable bit together, which opens a short window. A second write that clears the enable bit must land inside that window. A clearing write outside the window is ignored.

The control and status pins are plain level and strobe signals. No pin has a streaming handshake, so no back-pressure applies. A register write is taken on any clock edge where the write strobe is high.

Top module: `wdog_guarded`

## Requirements
- R1: While the synchronous active-high reset is held, the counter, the enable bit, the arming bit and the timeout select all clear to zero, `ctl_rdata` reads 0 and `sys_reset_o` is low.
- R2: The control layout is bits [2:0] = timeout select, bit 3 = enable and bit 4 = arming. Every write loads the select. A write with bit 3 set turns the watchdog on. `ctl_rdata` shows the register one cycle after the write.
- R3: A write with bits 4 and 3 both set opens a disable window. The arming bit then reads 1 for exactly four clock cycles after that write and reads 0 from the fifth cycle on.
- R4: A write with bit 3 clear that is taken on any of the four clock edges after the arming write turns the watchdog off and closes the window.
- R5: Outside a window, a write with bit 3 clear leaves the enable bit set. A write that sets bit 4 without bit 3 opens no window.
- R6: The counter advances by one only on a cycle where `osc_tick` is high and the watchdog is enabled. With select code s and base exponent B, the timeout is 2^(B+s) ticks. With the default B = 14, code 0 gives 16K ticks and code 7 gives 2048K ticks.
- R7: On timeout, `sys_reset_o` is high for exactly one clock cycle, in the cycle after the expiring tick. The counter returns to zero, and the enable bit and select keep their values.
- R8: `kick` clears the counter to zero. When `kick` and a tick arrive in the same cycle, the clear wins and no timeout occurs.
- R9: Turning the watchdog on does not clear the counter. Counting resumes from the value held when it was turned off.
- R10: The new select applies at once. If the count already reaches or passes the new limit minus one, the next enabled tick causes a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse for each watchdog oscillator period |
| kick | input | 1 | Restart strobe; clears the counter |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Write data: {arm, enable, select[2:0]} |
| ctl_rdata | output | 5 | Current control register: {arm, enable, select[2:0]} |
| sys_reset_o | output | 1 | One-cycle system reset pulse on timeout |

## Verification
A hidden counter that is wrong by even one step shows up as a timeout pulse one tick early or one tick late. The pulse appears within one limit period of the error, so the bench compares `sys_reset_o` with a reference model on every clock. A wrong arming state or window length shows up on the next clearing write, as an enable bit that falls when it should hold or holds when it should fall. The arming bit itself is visible on `ctl_rdata`, so a window that is one cycle too short or too long shows up in the cycle where it should close. Both ends of the window are probed: a clearing write on the fourth edge must succeed, and one on the fifth edge must fail.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W   = 3;
  localparam int NCODES  = 1 << SEL_W;
  localparam int CTL_W   = SEL_W + 2;
  localparam int EN_BIT  = SEL_W;
  localparam int ARM_BIT = SEL_W + 1;

  typedef struct packed {
    logic             arm;
    logic             en;
    logic [SEL_W-1:0] sel;
  } wdg_ctl_t;
endpackage

// File: rtl/wdg_ctl_reg.sv
module wdg_ctl_reg
  import wdg_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  wdg_ctl_t         wdata,
  output logic             en_o,
  output logic             arm_o,
  output logic [SEL_W-1:0] sel_o
);
  localparam int WC_W = $clog2(WIN + 1);

  logic [WC_W-1:0]  win_q;
  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic             win_open;
  logic             arm_req;
  logic             off_req;

  assign win_open = (win_q != '0);
  assign arm_req  = we && wdata.arm && wdata.en;
  assign off_req  = we && !wdata.en && win_open;

  // Guard window: reloaded by the arming write, closed by a successful
  // shutdown, otherwise drains by one per clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0;
    end else if (arm_req) begin
      win_q <= WC_W'(WIN);
    end else if (off_req) begin
      win_q <= '0;
    end else if (win_open) begin
      win_q <= win_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (we) begin
      sel_q <= wdata.sel;
      if (wdata.en) begin
        en_q <= 1'b1;
      end else if (win_open) begin
        en_q <= 1'b0;
      end
    end
  end

  assign en_o  = en_q;
  assign arm_o = win_open;
  assign sel_o = sel_q;

  assert_window_bound_R3: assert property (@(posedge clk) disable iff (rst)
    win_q <= WC_W'(WIN));

  assert_en_fall_guarded_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(en_q) |-> ($past(we) && $past(win_open)));

  assert_arm_needs_both_R5: assert property (@(posedge clk) disable iff (rst)
    (we && !(wdata.arm && wdata.en) && !win_open) |=> !win_open);
endmodule

// File: rtl/wdg_limit.sv
module wdg_limit
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int CNT_W     = BASE_LOG2 + NCODES - 1
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] term
);
  logic [CNT_W-1:0] tbl [NCODES];

  // Terminal count for code g is 2^(BASE_LOG2+g) - 1.
  for (genvar g = 0; g < NCODES; g++) begin : g_code
    assign tbl[g] = {CNT_W{1'b1}} >> (NCODES - 1 - g);
  end

  assign term = tbl[sel];
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 21
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] term,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic             hit;

  assign step = run && tick && !kick;
  assign hit  = step && (cnt_q >= term);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= hit;
      if (kick || hit) begin
        cnt_q <= '0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt_q == '0) && !expire_o);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (!kick && !(run && tick)) |=> (cnt_q == $past(cnt_q)));

  assert_expire_clears_R7: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> (cnt_q == '0));
endmodule

// File: rtl/wdog_guarded.sv
module wdog_guarded
  import wdg_pkg::*;
#(
  parameter int BASE_LOG2 = 14,
  parameter int WIN       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             kick,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             sys_reset_o
);
  localparam int CNT_W = BASE_LOG2 + NCODES - 1;

  wdg_ctl_t         wr_ctl;
  logic             en;
  logic             arm;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] term;

  assign wr_ctl = wdg_ctl_t'(ctl_wdata);

  wdg_ctl_reg #(.WIN(WIN)) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .we    (ctl_we),
    .wdata (wr_ctl),
    .en_o  (en),
    .arm_o (arm),
    .sel_o (sel)
  );

  wdg_limit #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_lim (
    .sel  (sel),
    .term (term)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (en),
    .tick     (osc_tick),
    .kick     (kick),
    .term     (term),
    .expire_o (sys_reset_o)
  );

  assign ctl_rdata = {arm, en, sel};

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    sys_reset_o |=> !sys_reset_o);

  assert_pulse_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
    sys_reset_o |-> $past(en && osc_tick && !kick));

  assert_pulse_keeps_ctl_R7: assert property (@(posedge clk) disable iff (rst)
    (sys_reset_o && !$past(ctl_we)) |-> (en && $stable(sel)));
endmodule

// File: tb/wdog_guarded_bench.sv
module wdog_guarded_bench;
  localparam int B = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       kick = 1'b0;
  logic       ctl_we = 1'b0;
  logic [4:0] ctl_wdata = 5'd0;
  logic [4:0] ctl_rdata;
  logic       sys_reset_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Reference model state
  int   m_cnt = 0;
  int   m_win = 0;
  logic m_en = 1'b0;
  int   m_sel = 0;
  logic m_rst = 1'b0;

  always #10 clk = ~clk;

  wdog_guarded #(.BASE_LOG2(B), .WIN(4)) u_wdog_guarded (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .kick(kick),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .sys_reset_o(sys_reset_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_win = 0; m_en = 1'b0; m_sel = 0; m_rst = 1'b0;
    end else begin
      logic fire;
      logic old_en;
      logic open;
      fire = 1'b0;
      old_en = m_en;
      open = (m_win > 0);
      if (kick) m_cnt = 0;
      else if (old_en && osc_tick) begin
        if (m_cnt >= (1 << (B + m_sel)) - 1) begin m_cnt = 0; fire = 1'b1; end
        else m_cnt++;
      end
      if (m_win > 0) m_win--;
      if (ctl_we) begin
        m_sel = ctl_wdata[2:0];
        if (ctl_wdata[4] && ctl_wdata[3]) begin m_en = 1'b1; m_win = 4; end
        else if (ctl_wdata[3]) m_en = 1'b1;
        else if (open) begin m_en = 1'b0; m_win = 0; end
      end
      m_rst = fire;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_req, " model reset out"}, sys_reset_o, m_rst);
      chk({cur_req, " model rdata"}, ctl_rdata, {(m_win > 0), m_en, m_sel[2:0]});
    end
  end

  always @(posedge clk) begin
    if (cycles == 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  task automatic cyc(input logic we, input logic [4:0] d, input logic rs, input logic tk);
    ctl_we = we; ctl_wdata = d; kick = rs; osc_tick = tk;
    @(negedge clk);
    ctl_we = 1'b0; kick = 1'b0; osc_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 5'd0, 1'b0, 1'b1);
      if (i % 3 == 1) idle(1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1 rdata in reset", ctl_rdata, 0);
    chk("R1 reset out in reset", sys_reset_o, 0);
    rst = 1'b0;
    idle(1);
    chk("R1 rdata after reset", ctl_rdata, 0);

    cur_req = "R2";
    cyc(1'b1, 5'b01000, 1'b0, 1'b0);
    chk("R2 enable readback", ctl_rdata, 5'b01000);

    cur_req = "R6";
    ticks(15);
    chk("R6 no timeout before limit", sys_reset_o, 0);
    cur_req = "R7";
    ticks(1);
    chk("R7 pulse after 16th tick", sys_reset_o, 1);
    idle(1);
    chk("R7 pulse one cycle", sys_reset_o, 0);
    chk("R7 control kept", ctl_rdata, 5'b01000);

    cur_req = "R8";
    ticks(10);
    cyc(1'b0, 5'd0, 1'b1, 1'b0);
    ticks(15);
    cyc(1'b0, 5'd0, 1'b1, 1'b1);
    chk("R8 kick beats tick", sys_reset_o, 0);
    ticks(15);
    chk("R8 full count after kick", sys_reset_o, 0);
    ticks(1);
    chk("R8 timeout after kick", sys_reset_o, 1);

    cur_req = "R10";
    cyc(1'b1, 5'b01010, 1'b1, 1'b0);
    chk("R2 select readback", ctl_rdata, 5'b01010);
    ticks(40);
    cyc(1'b1, 5'b01000, 1'b0, 1'b0);
    chk("R10 no pulse on select write", sys_reset_o, 0);
    ticks(1);
    chk("R10 immediate timeout", sys_reset_o, 1);

    cur_req = "R3";
    cyc(1'b0, 5'd0, 1'b1, 1'b0);
    ticks(5);
    cyc(1'b1, 5'b11000, 1'b0, 1'b0);
    chk("R3 arm set", ctl_rdata[4], 1);
    idle(3);
    chk("R3 arm still set", ctl_rdata[4], 1);
    idle(1);
    chk("R3 arm cleared after four", ctl_rdata[4], 0);

    cur_req = "R5";
    cyc(1'b1, 5'b00000, 1'b0, 1'b0);
    chk("R5 clear outside window ignored", ctl_rdata[3], 1);
    cyc(1'b1, 5'b10000, 1'b0, 1'b0);
    chk("R5 arm alone opens nothing", ctl_rdata[4], 0);
    chk("R5 arm alone keeps enable", ctl_rdata[3], 1);
    cyc(1'b1, 5'b11000, 1'b0, 1'b0);
    idle(4);
    cyc(1'b1, 5'b00000, 1'b0, 1'b0);
    chk("R5 clear on fifth edge ignored", ctl_rdata[3], 1);

    cur_req = "R4";
    cyc(1'b1, 5'b11000, 1'b0, 1'b0);
    idle(1);
    cyc(1'b1, 5'b00000, 1'b0, 1'b0);
    chk("R4 disabled inside window", ctl_rdata, 5'b00000);
    ticks(20);
    chk("R6 no count while off", sys_reset_o, 0);

    cur_req = "R9";
    cyc(1'b1, 5'b01000, 1'b0, 1'b0);
    ticks(10);
    chk("R9 resumed count below limit", sys_reset_o, 0);
    ticks(1);
    chk("R9 timeout from resumed count", sys_reset_o, 1);

    cur_req = "R4";
    cyc(1'b1, 5'b11000, 1'b0, 1'b0);
    idle(3);
    cyc(1'b1, 5'b00000, 1'b0, 1'b0);
    chk("R4 clear on fourth edge accepted", ctl_rdata[3], 0);

    idle(2);
    summary();
    $finish;
  end
endmodule